// File: doc/BRIEF.md
# Keyed Secondary-Core Reset Release

This block keeps a secondary processor core in reset until software stores one exact 8-bit release key in a control register. The release can also depend on a grant input from a security module. A parameter decides whether that grant is used. The block also holds four values that the core uses when it leaves reset: a 32-bit boot address, a 4-bit boot context, a 32-bit default non-maskable-interrupt vector and a 4-bit default interrupt context. These values drive the core at all times. The primary core loads them over a plain register port before it writes the key.

The block has two reset domains. The key register and the reset-hold output are cleared by the primary core's system reset. The four boot values are cleared only by the power-on reset, so they survive a system reset. The reset-hold output is registered. It follows the release condition one clock later.

Top module: `core_boot_gate`

## Requirements
- R1: After system reset the key field at offset 0x08 reads 0xC9 and `core_hold_o` is 1.
- R2: After power-on reset the boot address (0x00), boot context (0x04), interrupt vector (0x10) and interrupt context (0x14) read zero, and the matching outputs are zero.
- R3: A write at 0x00 or 0x10 stores all 32 bits. A write at 0x04 or 0x14 stores bits 3:0. A write at 0x08 stores bits 7:0. Unused upper bits of these registers read zero.
- R4: When the key holds 0x36 and the security grant is high, `core_hold_o` falls on the next rising edge. After a key write, that is the second edge counted from the edge that takes the write.
- R5: Any key value other than 0x36 (for example 0xC9, 0x37 or 0x00) keeps `core_hold_o` at 1.
- R6: With the security module enabled, a low grant keeps the core held even when the key is 0x36. If the grant falls after release, `core_hold_o` returns to 1 on the next edge.
- R7: Writing a key other than 0x36 after release sets `core_hold_o` back to 1 one edge after the key register updates.
- R8: System reset alone puts the key back to 0xC9 and sets `core_hold_o` at once. It leaves all four boot values unchanged.
- R9: The boot outputs always equal the stored register values. They are stable across the cycle in which `core_hold_o` falls.
- R10: Offsets other than 0x00, 0x04, 0x08, 0x10 and 0x14 read zero, and a write to them changes no register.
- R11: With `HAS_SEC_MOD` = 0 the grant input is ignored, and the key alone controls release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst_n | input | 1 | Primary-core system reset, active low, clears the key domain |
| por_rst_n | input | 1 | Power-on reset, active low, clears the boot values |
| bus_wr_en | input | 1 | Single-cycle write strobe |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sec_grant_i | input | 1 | Release grant from the security module |
| core_hold_o | output | 1 | 1 keeps the secondary core in reset |
| boot_addr_o | output | 32 | Boot address for the core |
| boot_ctx_o | output | 4 | Boot context for the core |
| nmi_addr_o | output | 32 | Default non-maskable-interrupt vector |
| nmi_ctx_o | output | 4 | Default non-maskable-interrupt context |

## Verification
The assertions assume the following about the inputs:
- The write strobe, address and data are synchronous to `clk` and stay steady through the edge that samples them.
- The security grant changes only between edges.
- Reset is asserted from time zero, so the one-cycle look-backs only ever see reset values.

The stimulus meets these assumptions by driving every input at the falling edge. It holds both resets from the start. It reads the combinational data port shortly after the falling edge, away from the rising edge that updates state.

// File: rtl/cbg_pkg.sv
package cbg_pkg;
  localparam int ADDR_W = 8;
  localparam int KEY_W  = 8;

  // Offsets decoded by software; kept fixed
  localparam logic [ADDR_W-1:0] OFS_BOOT_ADDR = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_BOOT_CTX  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_KEY       = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_NMI_ADDR  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_NMI_CTX   = 8'h14;

  // Release condition: key must match exactly, grant must be present
  function automatic logic key_releases(input logic [KEY_W-1:0] key,
                                        input logic [KEY_W-1:0] open_val,
                                        input logic             grant);
    return (key == open_val) && grant;
  endfunction
endpackage

// File: rtl/cbg_key_ctrl.sv
module cbg_key_ctrl
  import cbg_pkg::*;
#(
  parameter logic [KEY_W-1:0] KEY_RST  = 8'hC9,
  parameter logic [KEY_W-1:0] KEY_OPEN = 8'h36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_we,
  input  logic [KEY_W-1:0] key_wdata,
  input  logic             grant_ok,
  output logic [KEY_W-1:0] key_q,
  output logic             hold_o
);
  logic release_cond;
  logic key_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      key_q <= KEY_RST;
    else if (key_we) key_q <= key_wdata;
  end

  assign key_open     = (key_q == KEY_OPEN);
  assign release_cond = key_releases(key_q, KEY_OPEN, grant_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_o <= 1'b1;
    else        hold_o <= !release_cond;
  end

  // R4
  release_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_open && grant_ok) |=> !hold_o);
  // R5
  wrong_key_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !key_open |=> hold_o);
  // R6
  no_grant_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_ok |=> hold_o);
endmodule

// File: rtl/cbg_boot_store.sv
module cbg_boot_store #(
  parameter int DATA_W = 32,
  parameter int CTX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vec_we,
  input  logic              ctx_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] vec_q,
  output logic [CTX_W-1:0]  ctx_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      ctx_q <= '0;
    end else begin
      if (vec_we) vec_q <= wdata;
      if (ctx_we) ctx_q <= wdata[CTX_W-1:0];
    end
  end

  // R3
  vec_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_we |=> (vec_q == $past(wdata)));
  // R3
  ctx_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_we |=> (ctx_q == $past(wdata[CTX_W-1:0])));
  // R9
  hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_we && !ctx_we) |=> ($stable(vec_q) && $stable(ctx_q)));
endmodule

// File: rtl/core_boot_gate.sv
module core_boot_gate
  import cbg_pkg::*;
#(
  parameter int                HAS_SEC_MOD = 1,
  parameter int                DATA_W      = 32,
  parameter int                CTX_W       = 4,
  parameter logic [KEY_W-1:0]  KEY_RST     = 8'hC9,
  parameter logic [KEY_W-1:0]  KEY_OPEN    = 8'h36
) (
  input  logic              clk,
  input  logic              sys_rst_n,
  input  logic              por_rst_n,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sec_grant_i,
  output logic              core_hold_o,
  output logic [DATA_W-1:0] boot_addr_o,
  output logic [CTX_W-1:0]  boot_ctx_o,
  output logic [DATA_W-1:0] nmi_addr_o,
  output logic [CTX_W-1:0]  nmi_ctx_o
);
  localparam int NSTORE = 2;

  logic             key_we;
  logic [KEY_W-1:0] key_q;
  logic             grant_ok;

  logic [NSTORE-1:0]             vec_we, ctx_we;
  logic [NSTORE-1:0][DATA_W-1:0] vec_q;
  logic [NSTORE-1:0][CTX_W-1:0]  ctx_q;

  // Write strobes
  assign key_we    = bus_wr_en && (bus_addr == OFS_KEY);
  assign vec_we[0] = bus_wr_en && (bus_addr == OFS_BOOT_ADDR);
  assign ctx_we[0] = bus_wr_en && (bus_addr == OFS_BOOT_CTX);
  assign vec_we[1] = bus_wr_en && (bus_addr == OFS_NMI_ADDR);
  assign ctx_we[1] = bus_wr_en && (bus_addr == OFS_NMI_CTX);

  generate
    if (HAS_SEC_MOD != 0) begin : g_sec
      assign grant_ok = sec_grant_i;
    end else begin : g_nosec
      logic unused_grant;
      assign unused_grant = sec_grant_i;
      assign grant_ok     = 1'b1;
    end
  endgenerate

  cbg_key_ctrl #(.KEY_RST(KEY_RST), .KEY_OPEN(KEY_OPEN)) u_key (
    .clk       (clk),
    .rst_n     (sys_rst_n),
    .key_we    (key_we),
    .key_wdata (bus_wdata[KEY_W-1:0]),
    .grant_ok  (grant_ok),
    .key_q     (key_q),
    .hold_o    (core_hold_o)
  );

  generate
    for (genvar i = 0; i < NSTORE; i++) begin : g_store
      cbg_boot_store #(.DATA_W(DATA_W), .CTX_W(CTX_W)) u_store (
        .clk    (clk),
        .rst_n  (por_rst_n),
        .vec_we (vec_we[i]),
        .ctx_we (ctx_we[i]),
        .wdata  (bus_wdata),
        .vec_q  (vec_q[i]),
        .ctx_q  (ctx_q[i])
      );
    end
  endgenerate

  assign boot_addr_o = vec_q[0];
  assign boot_ctx_o  = ctx_q[0];
  assign nmi_addr_o  = vec_q[1];
  assign nmi_ctx_o   = ctx_q[1];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_BOOT_ADDR: bus_rdata = vec_q[0];
      OFS_BOOT_CTX:  bus_rdata[CTX_W-1:0] = ctx_q[0];
      OFS_KEY:       bus_rdata[KEY_W-1:0] = key_q;
      OFS_NMI_ADDR:  bus_rdata = vec_q[1];
      OFS_NMI_CTX:   bus_rdata[CTX_W-1:0] = ctx_q[1];
      default:       bus_rdata = '0;
    endcase
  end

  // R8
  sysrst_keeps_boot_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
    (!bus_wr_en) |=> $stable(boot_addr_o));
  // R9
  boot_out_stable_at_release_chk: assert property (@(posedge clk) disable iff (!por_rst_n || !sys_rst_n)
    $fell(core_hold_o) |-> ($stable(boot_addr_o) && $stable(boot_ctx_o)));
endmodule

// File: tb/tb_core_boot_gate.sv
`timescale 1ns/1ps
module tb_core_boot_gate;
  logic        clk = 1'b0;
  logic        sys_rst_n = 1'b0;
  logic        por_rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, rdata_ns;
  logic        sec_grant_i = 1'b1;
  logic        core_hold_o, hold_ns;
  logic [31:0] boot_addr_o, nmi_addr_o, ba_ns, na_ns;
  logic [3:0]  boot_ctx_o, nmi_ctx_o, bc_ns, nc_ns;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  core_boot_gate dut (
    .clk(clk), .sys_rst_n(sys_rst_n), .por_rst_n(por_rst_n),
    .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sec_grant_i(sec_grant_i), .core_hold_o(core_hold_o),
    .boot_addr_o(boot_addr_o), .boot_ctx_o(boot_ctx_o),
    .nmi_addr_o(nmi_addr_o), .nmi_ctx_o(nmi_ctx_o)
  );

  core_boot_gate #(.HAS_SEC_MOD(0)) dut_nosec (
    .clk(clk), .sys_rst_n(sys_rst_n), .por_rst_n(por_rst_n),
    .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata_ns), .sec_grant_i(1'b0), .core_hold_o(hold_ns),
    .boot_addr_o(ba_ns), .boot_ctx_o(bc_ns),
    .nmi_addr_o(na_ns), .nmi_ctx_o(nc_ns)
  );

  // {offset, write data, expected read-back}
  localparam logic [71:0] VEC [8] = '{
    {8'h00, 32'hDEADBEEF, 32'hDEADBEEF},
    {8'h04, 32'hFFFFFFFA, 32'h0000000A},
    {8'h10, 32'h12345678, 32'h12345678},
    {8'h14, 32'h000000F5, 32'h00000005},
    {8'h08, 32'hFFFF00C9, 32'h000000C9},
    {8'h0C, 32'hFFFFFFFF, 32'h00000000},
    {8'h08, 32'h00000037, 32'h00000037},
    {8'h08, 32'h00000000, 32'h00000000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected < 20000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] ba_prev;
    repeat (3) @(negedge clk);
    sys_rst_n = 1'b1; por_rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state of the key domain
    rd(8'h08, v); chk("R1 key reset value", v, 32'hC9);
    chk("R1 hold after reset", {31'b0, core_hold_o}, 32'd1);
    chk("R1 hold after reset (no sec)", {31'b0, hold_ns}, 32'd1);

    // R2 boot values cleared by power-on reset
    rd(8'h00, v); chk("R2 boot addr", v, 0);
    rd(8'h04, v); chk("R2 boot ctx", v, 0);
    rd(8'h10, v); chk("R2 nmi addr", v, 0);
    rd(8'h14, v); chk("R2 nmi ctx", v, 0);
    chk("R2 boot addr out", boot_addr_o, 0);

    // R3 R5 R10 vector table
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], v);
      chk($sformatf("R3/R10 table entry %0d", i), v, VEC[i][31:0]);
      @(negedge clk);
      chk($sformatf("R5 hold during table entry %0d", i), {31'b0, core_hold_o}, 32'd1);
    end
    // R10 the unmapped write left registers alone
    rd(8'h00, v); chk("R10 boot addr kept", v, 32'hDEADBEEF);
    rd(8'h14, v); chk("R10 nmi ctx kept", v, 32'h5);
    rd(8'h24, v); chk("R10 unmapped read", v, 0);
    chk("R9 nmi addr out", nmi_addr_o, 32'h12345678);
    chk("R9 nmi ctx out", {28'b0, nmi_ctx_o}, 32'h5);

    // R4 release with grant high
    wr(8'h08, 32'h36);
    chk("R4 hold one edge after key write", {31'b0, core_hold_o}, 32'd1);
    ba_prev = boot_addr_o;
    @(negedge clk);
    chk("R4 hold released", {31'b0, core_hold_o}, 32'd0);
    chk("R11 no-sec instance released", {31'b0, hold_ns}, 32'd0);
    chk("R9 boot addr at release", boot_addr_o, 32'hDEADBEEF);
    chk("R9 boot addr stable at release", boot_addr_o, ba_prev);
    chk("R9 boot ctx at release", {28'b0, boot_ctx_o}, 32'hA);

    // R6 grant removed after release
    sec_grant_i = 1'b0;
    @(negedge clk);
    chk("R6 hold returns on grant loss", {31'b0, core_hold_o}, 32'd1);
    chk("R11 no-sec ignores grant", {31'b0, hold_ns}, 32'd0);
    @(negedge clk);
    chk("R6 held while grant low", {31'b0, core_hold_o}, 32'd1);
    sec_grant_i = 1'b1;
    @(negedge clk);
    chk("R6 released when grant returns", {31'b0, core_hold_o}, 32'd0);

    // R7 wrong key after release
    wr(8'h08, 32'h35);
    @(negedge clk);
    chk("R7 hold after wrong key", {31'b0, core_hold_o}, 32'd1);
    chk("R7 no-sec hold after wrong key", {31'b0, hold_ns}, 32'd1);

    // R8 system reset alone
    wr(8'h08, 32'h36);
    @(negedge clk);
    chk("R8 released before sys reset", {31'b0, core_hold_o}, 32'd0);
    sys_rst_n = 1'b0;
    #1;
    chk("R8 hold set by sys reset", {31'b0, core_hold_o}, 32'd1);
    @(negedge clk);
    sys_rst_n = 1'b1;
    @(negedge clk);
    rd(8'h08, v); chk("R8 key back to reset value", v, 32'hC9);
    rd(8'h00, v); chk("R8 boot addr survives", v, 32'hDEADBEEF);
    rd(8'h10, v); chk("R8 nmi addr survives", v, 32'h12345678);

    // R2 power-on reset clears boot values
    por_rst_n = 1'b0;
    @(negedge clk);
    por_rst_n = 1'b1;
    @(negedge clk);
    rd(8'h00, v); chk("R2 boot addr after por", v, 0);
    rd(8'h14, v); chk("R2 nmi ctx after por", v, 0);
    chk("R2 boot addr out after por", boot_addr_o, 0);

    finish_run();
  end
endmodule